// File: doc/BRIEF.md
# Supervisor Power-Up Reset Sequencer

This block orders the start-up of a supply supervisor once its core logic has come out of power-on reset. It holds the active-low system reset low, keeps battery backup switched off and keeps the DAC/comparator and PWM peripherals disabled. It then waits for a brown-out comparator flag to say that the supply is above the minimum threshold plus hysteresis.

When the supply is good, the block registers a fuse word on a single cycle. That word carries a new brown-out threshold code, the frequency code for clock output 0, the enable for clock output 1 and the reset-duration choice. The duration comes from the sense pin or from a fuse field, depending on a fuse mode bit. A timer fed by a millisecond tick then turns on the clock outputs at a fixed point and releases reset when the chosen duration ends. If the supply drops before the sequence is complete, everything starts over.

Top module: `supv_startup_seq`

## Requirements
- R1: While `rst_n` is low, and until the supply is first reported good, `rst_out_n`, `clk0_en`, `clk1_en` and `bbk_en` are 0 and `periph_dis` is 1.
- R2: While `vbo_ok` is low in the waiting state, `ms_tick` pulses are not counted. Timing starts only after `vbo_ok` is seen high.
- R3: The first cycle `vbo_ok` is seen high is followed by a capture cycle that registers the fuse word (10 bits by default). `bo_sel` then shows fuse bits [9:7] and `clk0_freq` shows fuse bits [6:4]. Changes to `fuse_word` or `sense_pin` after the capture have no effect on any output.
- R4: If fuse bit 0 is 1, the sense pin picks the duration: low gives 10 ms and high gives 200 ms. If fuse bit 0 is 0, fuse bits [2:1] pick it: 0 gives 1 ms, 1 gives 10 ms, 2 gives 100 ms and 3 gives 200 ms.
- R5: Ticks are counted starting in the cycle after the capture. `rst_out_n` goes high right after the tick that brings the count to the selected duration. `bbk_en` goes high together with it.
- R6: `clk0_en` goes high right after the 4th counted tick. `clk1_en` goes high at the same time, but only when fuse bit 3 is 1.
- R7: `periph_dis` stays 1 until both the reset release and the clock enable have happened. It falls one cycle after the later of the two.
- R8: If `vbo_ok` goes low before `periph_dis` falls, the next cycle shows the R1 output state. The tick count is cleared, so a new sequence counts from zero.
- R9: Once `periph_dis` has fallen, `vbo_ok` has no further effect: the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low power-on reset |
| vbo_ok | input | 1 | brown-out comparator: supply above threshold |
| fuse_word | input | 10 | configuration fuse bits |
| sense_pin | input | 1 | reset-duration sense pin |
| ms_tick | input | 1 | one-cycle pulse every millisecond |
| rst_out_n | output | 1 | active-low system reset |
| clk0_en | output | 1 | clock output 0 enable |
| clk1_en | output | 1 | clock output 1 enable |
| clk0_freq | output | 3 | latched frequency code for clock output 0 |
| bo_sel | output | 3 | latched brown-out threshold code |
| bbk_en | output | 1 | battery-backup switchover enable |
| periph_dis | output | 1 | DAC/comparator and PWM disable |

## Verification
A timer that is off by one count shows up as `rst_out_n` or `clk0_en` rising one tick early or one tick late. The bench steps one tick at a time so that a single-count error is caught at the tick where it happens. A wrongly registered configuration appears at once on `bo_sel` and `clk0_freq`, or later as the wrong release tick. A state machine that fails to fall back on a supply drop leaves reset high in the very next cycle. A timer that is not cleared makes the clock enables come back before the fourth tick of the restarted sequence.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_LATCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_st_e;

  localparam int DUR_CODES = 4;
  localparam logic [1:0] SENSE_LO_CODE = 2'd1;
  localparam logic [1:0] SENSE_HI_CODE = 2'd3;
endpackage

// File: rtl/supv_cfg_latch.sv
module supv_cfg_latch
  import supv_pkg::*;
#(
  parameter int BO_W   = 3,
  parameter int FREQ_W = 3,
  parameter int TMR_W  = 8,
  parameter int DUR_C0 = 1,
  parameter int DUR_C1 = 10,
  parameter int DUR_C2 = 100,
  parameter int DUR_C3 = 200,
  localparam int FUSE_W = 4 + FREQ_W + BO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [FUSE_W-1:0] fuse,
  input  logic              sense,
  output logic [BO_W-1:0]   bo_sel,
  output logic [FREQ_W-1:0] freq,
  output logic              clk1_on,
  output logic [TMR_W-1:0]  dur_lim
);
  localparam int DUR_TAB [DUR_CODES] = '{DUR_C0, DUR_C1, DUR_C2, DUR_C3};

  logic [1:0]        code_d, code_q;
  logic [BO_W-1:0]   bo_q;
  logic [FREQ_W-1:0] freq_q;
  logic              c1_q;
  logic [TMR_W-1:0]  lim_tab [DUR_CODES];

  always_comb begin
    if (fuse[0]) code_d = sense ? SENSE_HI_CODE : SENSE_LO_CODE;
    else         code_d = fuse[2:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      bo_q   <= '0;
      freq_q <= '0;
      c1_q   <= 1'b0;
    end else if (cap_en) begin
      code_q <= code_d;
      c1_q   <= fuse[3];
      freq_q <= fuse[4 +: FREQ_W];
      bo_q   <= fuse[4+FREQ_W +: BO_W];
    end
  end

  for (genvar g = 0; g < DUR_CODES; g++) begin : g_lim
    assign lim_tab[g] = TMR_W'(DUR_TAB[g]);
  end

  assign dur_lim = lim_tab[code_q];
  assign bo_sel  = bo_q;
  assign freq    = freq_q;
  assign clk1_on = c1_q;
endmodule

// File: rtl/supv_ms_timer.sv
module supv_ms_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [TMR_W-1:0] end_cnt,
  output logic [TMR_W-1:0] cnt,
  output logic             at_end
);
  logic [TMR_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  assign at_end = (cnt_q >= end_cnt);
  assign cnt_en = clr | (tick & ~at_end);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/supv_seq_fsm.sv
module supv_seq_fsm
  import supv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    vbo_ok,
  input  logic    at_end,
  output seq_st_e state,
  output logic    cap_en,
  output logic    tmr_clr
);
  seq_st_e st_d, st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT:  if (vbo_ok) st_d = ST_LATCH;
      ST_LATCH: st_d = vbo_ok ? ST_RUN : ST_WAIT;
      ST_RUN: begin
        if (!vbo_ok)     st_d = ST_WAIT;
        else if (at_end) st_d = ST_DONE;
      end
      ST_DONE:  st_d = ST_DONE;
      default:  st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT;
    else        st_q <= st_d;
  end

  assign state   = st_q;
  assign cap_en  = (st_q == ST_LATCH);
  assign tmr_clr = (st_q != ST_RUN);
endmodule

// File: rtl/supv_startup_seq.sv
module supv_startup_seq
  import supv_pkg::*;
#(
  parameter int BO_W     = 3,
  parameter int FREQ_W   = 3,
  parameter int CLKEN_MS = 4,
  parameter int DUR_C0   = 1,
  parameter int DUR_C1   = 10,
  parameter int DUR_C2   = 100,
  parameter int DUR_C3   = 200,
  localparam int FUSE_W  = 4 + FREQ_W + BO_W,
  localparam int MAX_A   = (DUR_C0 > DUR_C1) ? DUR_C0 : DUR_C1,
  localparam int MAX_B   = (DUR_C2 > DUR_C3) ? DUR_C2 : DUR_C3,
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int MAX_ALL = (MAX_C > CLKEN_MS) ? MAX_C : CLKEN_MS,
  localparam int TMR_W   = $clog2(MAX_ALL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbo_ok,
  input  logic [FUSE_W-1:0] fuse_word,
  input  logic              sense_pin,
  input  logic              ms_tick,
  output logic              rst_out_n,
  output logic              clk0_en,
  output logic              clk1_en,
  output logic [FREQ_W-1:0] clk0_freq,
  output logic [BO_W-1:0]   bo_sel,
  output logic              bbk_en,
  output logic              periph_dis
);
  localparam logic [TMR_W-1:0] CLKEN_CNT = TMR_W'(CLKEN_MS);

  logic [1:0]       rs_q;
  logic             core_rst_n;
  seq_st_e          state;
  logic             cap_en, tmr_clr, at_end, clk1_on;
  logic [TMR_W-1:0] cnt, dur_lim, end_cnt;
  logic             in_run, in_done, released, clk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  supv_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .vbo_ok  (vbo_ok),
    .at_end  (at_end),
    .state   (state),
    .cap_en  (cap_en),
    .tmr_clr (tmr_clr)
  );

  supv_cfg_latch #(
    .BO_W   (BO_W),
    .FREQ_W (FREQ_W),
    .TMR_W  (TMR_W),
    .DUR_C0 (DUR_C0),
    .DUR_C1 (DUR_C1),
    .DUR_C2 (DUR_C2),
    .DUR_C3 (DUR_C3)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .cap_en  (cap_en),
    .fuse    (fuse_word),
    .sense   (sense_pin),
    .bo_sel  (bo_sel),
    .freq    (clk0_freq),
    .clk1_on (clk1_on),
    .dur_lim (dur_lim)
  );

  assign end_cnt = (dur_lim > CLKEN_CNT) ? dur_lim : CLKEN_CNT;

  supv_ms_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (tmr_clr),
    .tick    (ms_tick),
    .end_cnt (end_cnt),
    .cnt     (cnt),
    .at_end  (at_end)
  );

  assign in_run   = (state == ST_RUN);
  assign in_done  = (state == ST_DONE);
  assign released = in_done | (in_run & (cnt >= dur_lim));
  assign clk_on   = in_done | (in_run & (cnt >= CLKEN_CNT));

  assign rst_out_n  = released;
  assign bbk_en     = released;
  assign clk0_en    = clk_on;
  assign clk1_en    = clk_on & clk1_on;
  assign periph_dis = ~in_done;
endmodule

// File: rtl/supv_startup_chk.sv
module supv_startup_chk #(
  parameter int BO_W   = 3,
  parameter int FREQ_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vbo_ok,
  input logic              rst_out_n,
  input logic              clk0_en,
  input logic              bbk_en,
  input logic              periph_dis,
  input logic [FREQ_W-1:0] clk0_freq,
  input logic [BO_W-1:0]   bo_sel
);
  a_r1_por_holds_reset: assert property (@(posedge clk)
    !rst_n |-> (!rst_out_n && !clk0_en && !bbk_en && periph_dis));

  a_r8_drop_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbo_ok && periph_dis) |=> (!rst_out_n && !clk0_en && !bbk_en));

  a_r5_release_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && vbo_ok) |=> rst_out_n);

  a_r6_clk0_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (clk0_en && vbo_ok) |=> clk0_en);

  a_r7_periph_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_dis |-> (rst_out_n && clk0_en));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_dis |=> (!periph_dis && rst_out_n && bbk_en));

  a_r3_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && vbo_ok) |=> ($stable(bo_sel) && $stable(clk0_freq)));
endmodule

bind supv_startup_seq supv_startup_chk #(.BO_W(BO_W), .FREQ_W(FREQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vbo_ok     (vbo_ok),
  .rst_out_n  (rst_out_n),
  .clk0_en    (clk0_en),
  .bbk_en     (bbk_en),
  .periph_dis (periph_dis),
  .clk0_freq  (clk0_freq),
  .bo_sel     (bo_sel)
);

// File: tb/test_supv_startup_seq.sv
module test_supv_startup_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       vbo_ok;
  logic [9:0] fuse_word;
  logic       sense_pin;
  logic       ms_tick;
  logic       rst_out_n, clk0_en, clk1_en, bbk_en, periph_dis;
  logic [2:0] clk0_freq, bo_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  supv_startup_seq i_supv_startup_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .vbo_ok     (vbo_ok),
    .fuse_word  (fuse_word),
    .sense_pin  (sense_pin),
    .ms_tick    (ms_tick),
    .rst_out_n  (rst_out_n),
    .clk0_en    (clk0_en),
    .clk1_en    (clk1_en),
    .clk0_freq  (clk0_freq),
    .bo_sel     (bo_sel),
    .bbk_en     (bbk_en),
    .periph_dis (periph_dis)
  );

  // vector: {fuse[9:0], sense}, expected duration in ms
  localparam int NV = 6;
  localparam logic [10:0] V_IN [NV] = '{
    {10'b000_000_0_00_0, 1'b0},
    {10'b001_010_1_01_0, 1'b1},
    {10'b111_111_0_10_0, 1'b0},
    {10'b010_001_1_11_0, 1'b0},
    {10'b000_000_0_11_1, 1'b0},
    {10'b101_011_1_00_1, 1'b1}
  };
  localparam int V_DUR [NV] = '{1, 10, 100, 200, 10, 200};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vbo_ok = 1'b0; ms_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // vbo_ok goes high; after two edges the sequencer is counting
  task automatic go();
    @(negedge clk) vbo_ok = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    chk("SUMMARY", n_fail, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    fuse_word = '0; sense_pin = 1'b0;
    rst_n = 1'b0; vbo_ok = 1'b0; ms_tick = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 rst_out_n", rst_out_n, 0);
    chk("R1 clk0_en", clk0_en, 0);
    chk("R1 bbk_en", bbk_en, 0);
    chk("R1 periph_dis", periph_dis, 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int dur, last;
      logic c1;
      do_reset();
      fuse_word = V_IN[v][10:1];
      sense_pin = V_IN[v][0];
      c1   = V_IN[v][4];
      dur  = V_DUR[v];
      last = (dur > 4) ? dur : 4;
      go();
      chk("R3 bo_sel", bo_sel, V_IN[v][10:8]);
      chk("R3 clk0_freq", clk0_freq, V_IN[v][7:5]);
      chk("R1 rst_out_n before ticks", rst_out_n, 0);
      for (int k = 1; k <= last; k++) begin
        tick();
        chk("R4 R5 rst_out_n", rst_out_n, (k >= dur) ? 1 : 0);
        chk("R5 bbk_en", bbk_en, (k >= dur) ? 1 : 0);
        chk("R6 clk0_en", clk0_en, (k >= 4) ? 1 : 0);
        chk("R6 clk1_en", clk1_en, (k >= 4 && c1) ? 1 : 0);
        chk("R7 periph_dis during run", periph_dis, 1);
      end
      @(negedge clk);
      chk("R7 periph_dis after done", periph_dis, 0);
    end

    // R2: ticks ignored while supply is low
    do_reset();
    fuse_word = 10'b000_000_0_00_0; sense_pin = 1'b0;
    for (int k = 0; k < 6; k++) tick();
    chk("R2 rst_out_n while waiting", rst_out_n, 0);
    chk("R2 clk0_en while waiting", clk0_en, 0);
    go();
    repeat (3) tick();
    chk("R2 clk0_en after 3 counted ticks", clk0_en, 0);
    tick();
    chk("R2 clk0_en after 4 counted ticks", clk0_en, 1);

    // R3: inputs changed after capture have no effect
    do_reset();
    fuse_word = 10'b011_101_0_01_0; sense_pin = 1'b0;
    go();
    fuse_word = 10'b100_010_1_00_1; sense_pin = 1'b1;
    for (int k = 1; k < 10; k++) tick();
    chk("R3 rst_out_n held after fuse change", rst_out_n, 0);
    chk("R3 clk1_en after fuse change", clk1_en, 0);
    chk("R3 bo_sel after fuse change", bo_sel, 3'b011);
    chk("R3 clk0_freq after fuse change", clk0_freq, 3'b101);
    tick();
    chk("R3 rst_out_n at original 10 ms", rst_out_n, 1);

    // R8: supply drop mid-sequence restarts from zero
    do_reset();
    fuse_word = 10'b000_000_1_01_0; sense_pin = 1'b0;
    go();
    repeat (6) tick();
    chk("R8 clk0_en before drop", clk0_en, 1);
    @(negedge clk) vbo_ok = 1'b0;
    @(negedge clk);
    chk("R8 rst_out_n after drop", rst_out_n, 0);
    chk("R8 clk0_en after drop", clk0_en, 0);
    chk("R8 clk1_en after drop", clk1_en, 0);
    chk("R8 bbk_en after drop", bbk_en, 0);
    go();
    repeat (3) tick();
    chk("R8 clk0_en after 3 ticks of restart", clk0_en, 0);
    tick();
    chk("R8 clk0_en after 4 ticks of restart", clk0_en, 1);
    repeat (6) tick();
    chk("R8 rst_out_n at 10 ms of restart", rst_out_n, 1);

    // R9: supply drop after completion is ignored
    @(negedge clk);
    chk("R9 periph_dis done", periph_dis, 0);
    vbo_ok = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 rst_out_n after late drop", rst_out_n, 1);
    chk("R9 periph_dis after late drop", periph_dis, 0);
    chk("R9 clk0_en after late drop", clk0_en, 1);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 rst_out_n on async reset", rst_out_n, 0);
    chk("R1 periph_dis on async reset", periph_dis, 1);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule